// File: doc/BRIEF.md
# Circular log writer with sentinel

This controller keeps a running byte value in a ring of cells inside a byte-addressable nonvolatile memory. Each new value goes into its own slot, so wear is spread over the whole ring rather than piling onto one address. The slot that follows the newest entry always holds the empty code 0xFF. After power-up the controller finds that empty slot and carries on from it, with no separate pointer cell that could wear out.

Every write is gated by a read. On an update the controller reads the newest stored entry and does not write if the new value is the same. After it writes a value, it reads the following slot and writes the empty code there only if that slot does not already hold it. The memory needs a long programming time after every write. A local timer enforces that time, and the controller also obeys the memory's busy flag.

The host sees a simple request/done handshake, the newest logged value and a flag that reports a blank ring. The memory side is a plain port with an address, write data, read data, read and write strobes, and a busy input.

Top module: `logw_ring_writer`

## Requirements
- R1: After reset the controller reads the ring slots in order, starting at index 0 (address RING_BASE). The first slot that reads 0xFF becomes the write slot, and `upd_ready` rises once the scan has finished.
- R2: When `upd_ready` first rises after a scan that found 0xFF, `newest_val` holds the contents of the slot just before the write slot. The slot before index 0 is index RING_LEN-1.
- R3: If no ring slot reads 0xFF, `ring_blank` goes high and the write slot is index 0. `newest_val` reads 0xFF, and `ring_blank` stays high until the next reset.
- R4: An accepted update first reads the newest entry. If the stored byte equals the requested byte, no write strobe is issued and the done pulse carries `upd_skip`=1.
- R5: Otherwise the byte is written to the write slot and the following slot is read. 0xFF is written there only if that slot does not already hold 0xFF. The write slot then advances by one, `newest_val` becomes the new byte and `upd_skip`=0.
- R6: The slot after index RING_LEN-1 is index 0, both for the empty marker and for the write slot.
- R7: No read or write strobe is issued while `mem_busy` is high. After a write strobe, the next strobe comes at least PROG_CYCLES+1 cycles later.
- R8: `upd_req` is accepted only in a cycle where `upd_ready` is high. A request made while the scan or an update sequence is running has no effect: no done pulse, no memory write, and `newest_val` is unchanged.
- R9: A request to log 0xFF is answered with a done pulse that carries `upd_skip`=1. It issues no memory access and leaves `newest_val` unchanged.
- R10: Each accepted request gives exactly one `upd_done` pulse, one cycle wide. `newest_val` and `upd_skip` are valid in that cycle.
- R11: Strobes touch only addresses RING_BASE to RING_BASE+RING_LEN-1, and never a read and a write together. Read data is taken in the cycle after the one-cycle read strobe.
- R12: While `rst_n` is low, `mem_rd`, `mem_wr`, `upd_done` and `upd_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_req | input | 1 | Host request to log `upd_data` |
| upd_data | input | DATA_W | Byte to log |
| upd_ready | output | 1 | Controller idle; a request is accepted this cycle |
| upd_done | output | 1 | One-cycle pulse when a request has finished |
| upd_skip | output | 1 | With `upd_done`: no data write was made |
| newest_val | output | DATA_W | Newest logged byte |
| ring_blank | output | 1 | Scan found no empty marker |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after `mem_rd` |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_busy | input | 1 | Memory is still programming |

## Verification
The bound checker tests the memory-side rules on every cycle: a read and a write never occur together, addresses stay inside the ring, no access starts while the memory is busy, and the programming gap after each write is kept. It also checks that `upd_done` is one cycle wide, that the blank flag holds, and that `newest_val` stays put while the controller is idle. Other behaviour needs whole stimulus scenarios from the bench. These are where the scan places the write slot and which entry it restores, skipping on an equal value, skipping the marker write when the next slot is already empty, wrap-around at the end of the ring, recovery from a blank ring, and requests ignored during a scan or an update.

// File: rtl/logw_pkg.sv
// Shared types for the circular log writer.
// Assumes: nothing beyond the standard language.
package logw_pkg;

    // Controller sequence states
    typedef enum logic [3:0] {
        S_BOOT,
        S_SCAN_RD,
        S_SCAN_CHK,
        S_LAST_RD,
        S_LAST_CHK,
        S_IDLE,
        S_CMP_RD,
        S_CMP_CHK,
        S_WR_DATA,
        S_NXT_RD,
        S_NXT_CHK,
        S_WR_MARK,
        S_DONE
    } logw_state_e;

endpackage

// File: rtl/logw_ring_step.sv
// Gives the next and previous slot index in a ring of RING_LEN slots.
// Assumes: slot < RING_LEN. A power-of-two length uses natural wrap;
// any other length compares against the last index.
module logw_ring_step #(
    parameter int RING_LEN = 16,
    parameter int SLOT_W   = 4
) (
    input  logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] slot_nxt,
    output logic [SLOT_W-1:0] slot_prv
);

    generate
        if ((RING_LEN & (RING_LEN - 1)) == 0) begin : g_pow2
            // Wrap comes free from the index width
            assign slot_nxt = slot + SLOT_W'(1);
            assign slot_prv = slot - SLOT_W'(1);
        end else begin : g_any
            localparam logic [SLOT_W-1:0] LAST = SLOT_W'(RING_LEN - 1);
            // Explicit wrap at both ends of the ring
            assign slot_nxt = (slot == LAST) ? '0 : slot + SLOT_W'(1);
            assign slot_prv = (slot == '0) ? LAST : slot - SLOT_W'(1);
        end
    endgenerate

endmodule

// File: rtl/logw_prog_timer.sv
// Keeps the programming window after each memory write and combines it
// with the memory busy flag into one access-permitted signal.
// Assumes: start is the write strobe itself and is high for one cycle.
module logw_prog_timer #(
    parameter int PROG_CYCLES = 500000,
    parameter int CNT_W       = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mem_busy,
    output logic can_go
);

    logic [CNT_W-1:0] cnt_q;

    // Load the window on a write, then count it down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(PROG_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Access allowed once the window is over and the memory is idle
    assign can_go = (cnt_q == '0) && !mem_busy;

endmodule

// File: rtl/logw_ring_writer.sv
// Circular log writer. Scans the ring for the empty marker after reset,
// then logs host bytes with read-before-write gating. It writes the data
// byte and then, if needed, the empty marker in the following slot.
// Assumes: a synchronous memory with read data valid one cycle after the
// read strobe. A busy flag covers the memory's own write time.
// RING_LEN >= 3.
module logw_ring_writer
    import logw_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int RING_BASE   = 16,
    parameter int RING_LEN    = 16,
    parameter int PROG_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_req,
    input  logic [DATA_W-1:0] upd_data,
    output logic              upd_ready,
    output logic              upd_done,
    output logic              upd_skip,
    output logic [DATA_W-1:0] newest_val,
    output logic              ring_blank,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              mem_busy
);

    localparam int SLOT_W = (RING_LEN > 1) ? $clog2(RING_LEN) : 1;
    localparam int CNT_W  = $clog2(PROG_CYCLES + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(RING_LEN - 1);
    localparam logic [DATA_W-1:0] EMPTY     = '1;

    logw_state_e       state_q;
    logic [SLOT_W-1:0] scan_idx_q;
    logic [SLOT_W-1:0] ptr_q;
    logic [SLOT_W-1:0] ptr_nxt;
    logic [SLOT_W-1:0] ptr_prv;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] newest_q;
    logic              blank_q;
    logic              skip_q;
    logic              can_go;
    logic              rd_req;
    logic              wr_req;
    logic [SLOT_W-1:0] slot_sel;
    logic [DATA_W-1:0] wdata_sel;

    // Neighbour slots of the write slot
    logw_ring_step #(
        .RING_LEN (RING_LEN),
        .SLOT_W   (SLOT_W)
    ) u_step (
        .slot     (ptr_q),
        .slot_nxt (ptr_nxt),
        .slot_prv (ptr_prv)
    );

    // Programming window and busy gate shared by every access
    logw_prog_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .CNT_W       (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (mem_wr),
        .mem_busy (mem_busy),
        .can_go   (can_go)
    );

    // Pick the access each state wants and the slot it targets
    always_comb begin
        rd_req    = 1'b0;
        wr_req    = 1'b0;
        slot_sel  = ptr_q;
        wdata_sel = data_q;
        case (state_q)
            S_SCAN_RD: begin
                rd_req   = 1'b1;
                slot_sel = scan_idx_q;
            end
            S_LAST_RD, S_CMP_RD: begin
                rd_req   = 1'b1;
                slot_sel = ptr_prv;
            end
            S_WR_DATA: begin
                wr_req   = 1'b1;
                slot_sel = ptr_q;
            end
            S_NXT_RD: begin
                rd_req   = 1'b1;
                slot_sel = ptr_nxt;
            end
            S_WR_MARK: begin
                wr_req    = 1'b1;
                slot_sel  = ptr_nxt;
                wdata_sel = EMPTY;
            end
            default: begin
                rd_req = 1'b0;
            end
        endcase
    end

    // Memory strobes fire only when the gate allows
    assign mem_rd    = rd_req & can_go;
    assign mem_wr    = wr_req & can_go;
    assign mem_addr  = ADDR_W'(RING_BASE) + ADDR_W'(slot_sel);
    assign mem_wdata = wdata_sel;

    // Main sequence: scan, restore, then compare-gated logging
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_BOOT;
            scan_idx_q <= '0;
            ptr_q      <= '0;
            data_q     <= '0;
            newest_q   <= EMPTY;
            blank_q    <= 1'b0;
            skip_q     <= 1'b0;
        end else begin
            case (state_q)
                S_BOOT: begin
                    state_q <= S_SCAN_RD;
                end
                S_SCAN_RD: begin
                    if (can_go) state_q <= S_SCAN_CHK;
                end
                S_SCAN_CHK: begin
                    if (mem_rdata == EMPTY) begin
                        ptr_q   <= scan_idx_q;
                        state_q <= S_LAST_RD;
                    end else if (scan_idx_q == LAST_SLOT) begin
                        blank_q  <= 1'b1;
                        ptr_q    <= '0;
                        newest_q <= EMPTY;
                        state_q  <= S_IDLE;
                    end else begin
                        scan_idx_q <= scan_idx_q + SLOT_W'(1);
                        state_q    <= S_SCAN_RD;
                    end
                end
                S_LAST_RD: begin
                    if (can_go) state_q <= S_LAST_CHK;
                end
                S_LAST_CHK: begin
                    newest_q <= mem_rdata;
                    state_q  <= S_IDLE;
                end
                S_IDLE: begin
                    if (upd_req) begin
                        data_q <= upd_data;
                        if (upd_data == EMPTY) begin
                            skip_q  <= 1'b1;
                            state_q <= S_DONE;
                        end else begin
                            state_q <= S_CMP_RD;
                        end
                    end
                end
                S_CMP_RD: begin
                    if (can_go) state_q <= S_CMP_CHK;
                end
                S_CMP_CHK: begin
                    if (mem_rdata == data_q) begin
                        skip_q  <= 1'b1;
                        state_q <= S_DONE;
                    end else begin
                        state_q <= S_WR_DATA;
                    end
                end
                S_WR_DATA: begin
                    if (can_go) state_q <= S_NXT_RD;
                end
                S_NXT_RD: begin
                    if (can_go) state_q <= S_NXT_CHK;
                end
                S_NXT_CHK: begin
                    if (mem_rdata == EMPTY) begin
                        skip_q   <= 1'b0;
                        ptr_q    <= ptr_nxt;
                        newest_q <= data_q;
                        state_q  <= S_DONE;
                    end else begin
                        state_q <= S_WR_MARK;
                    end
                end
                S_WR_MARK: begin
                    if (can_go) begin
                        skip_q   <= 1'b0;
                        ptr_q    <= ptr_nxt;
                        newest_q <= data_q;
                        state_q  <= S_DONE;
                    end
                end
                S_DONE: begin
                    state_q <= S_IDLE;
                end
                default: begin
                    state_q <= S_BOOT;
                end
            endcase
        end
    end

    // Host-side outputs decoded from registered state
    assign upd_ready  = (state_q == S_IDLE);
    assign upd_done   = (state_q == S_DONE);
    assign upd_skip   = skip_q;
    assign newest_val = newest_q;
    assign ring_blank = blank_q;

endmodule

// File: rtl/logw_ring_writer_chk.sv
// Protocol checker for the circular log writer, bound to every instance.
// Assumes: the same parameters as the bound module.
module logw_ring_writer_chk #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int RING_BASE   = 16,
    parameter int RING_LEN    = 16,
    parameter int PROG_CYCLES = 500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_req,
    input logic              upd_ready,
    input logic              upd_done,
    input logic [DATA_W-1:0] newest_val,
    input logic              ring_blank,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_busy
);

    localparam int GAP_W = $clog2(PROG_CYCLES + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(PROG_CYCLES);

    logic [GAP_W-1:0] gap_q;
    logic             seen_wr_q;

    // Count idle cycles since the last write strobe, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q     <= '0;
            seen_wr_q <= 1'b0;
        end else if (mem_wr) begin
            gap_q     <= '0;
            seen_wr_q <= 1'b1;
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R11

    AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (32'(mem_addr) >= RING_BASE) &&
                               (32'(mem_addr) < RING_BASE + RING_LEN)); // R11

    AST_NOT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> !mem_busy); // R7

    AST_PROG_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && seen_wr_q) |-> (gap_q >= GAP_MAX)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done); // R10

    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ring_blank |=> ring_blank); // R3

    AST_IDLE_KEEPS_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ready && !upd_req) |=> $stable(newest_val)); // R8

endmodule

bind logw_ring_writer logw_ring_writer_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .RING_BASE   (RING_BASE),
    .RING_LEN    (RING_LEN),
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_req    (upd_req),
    .upd_ready  (upd_ready),
    .upd_done   (upd_done),
    .newest_val (newest_val),
    .ring_blank (ring_blank),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_busy   (mem_busy)
);

// File: tb/tb_logw_ring_writer.sv
// Scoreboard bench for the circular log writer with a behavioural memory.
module tb_logw_ring_writer;

    localparam int AW   = 6;
    localparam int BASE = 8;
    localparam int LEN  = 5;
    localparam int PROG = 6;

    typedef struct {
        bit         skip;
        logic [7:0] newest;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          upd_req = 1'b0;
    logic [7:0]    upd_data = 8'h00;
    logic          upd_ready, upd_done, upd_skip, ring_blank;
    logic [7:0]    newest_val;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic          mem_rd, mem_wr, mem_busy;

    int n_chk = 0;
    int n_fail = 0;
    exp_t exp_q[$];

    // Memory model state
    logic [7:0] mem [0:(1<<AW)-1];
    logic [7:0] load_pat [0:LEN-1];
    bit         load_now = 1'b0;
    int         busy_len = 3;
    int         busy_cnt = 0;
    int         wr_total = 0;
    int         cyc = 0;
    int         last_wr = -1000;

    logw_ring_writer #(
        .ADDR_W(AW), .DATA_W(8), .RING_BASE(BASE), .RING_LEN(LEN), .PROG_CYCLES(PROG)
    ) dut (
        .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .upd_data(upd_data),
        .upd_ready(upd_ready), .upd_done(upd_done), .upd_skip(upd_skip),
        .newest_val(newest_val), .ring_blank(ring_blank), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_busy(mem_busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    assign mem_busy = (busy_cnt != 0);

    // Behavioural memory: registered read, write with busy time, protocol checks
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (load_now) begin
            for (int a = 0; a < (1 << AW); a++) begin
                if (a >= BASE && a < BASE + LEN) mem[a] <= load_pat[a - BASE];
                else if (a == BASE - 1)          mem[a] <= 8'hA5;
                else if (a == BASE + LEN)        mem[a] <= 8'h5A;
                else                             mem[a] <= 8'h00;
            end
        end
        if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
        if (rst_n && (mem_rd || mem_wr)) begin
            chk(!mem_busy, "R7", "strobe while busy", 32'(mem_busy), 0);
            chk(cyc - last_wr >= PROG + 1, "R7", "programming gap",
                32'(cyc - last_wr), PROG + 1);
            chk(!(mem_rd && mem_wr), "R11", "both strobes", 1, 0);
        end
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
            wr_total <= wr_total + 1;
            busy_cnt <= busy_len;
            last_wr  <= cyc;
        end
    end

    // Scoreboard monitor: every done pulse must match the next expected item
    always @(negedge clk) begin
        if (rst_n && upd_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected done pulse", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(upd_skip == e.skip, e.req, "skip flag", 32'(upd_skip), 32'(e.skip));
                chk(newest_val == e.newest, e.req, "newest value", 32'(newest_val),
                    32'(e.newest));
            end
        end
    end

    task automatic wait_ready();
        int n = 0;
        @(negedge clk);
        while (!upd_ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Reset the design with a given ring image; check outputs while in reset
    task automatic do_reset(input logic [7:0] p0, p1, p2, p3, p4);
        @(negedge clk);
        rst_n = 1'b0;
        load_pat[0] = p0; load_pat[1] = p1; load_pat[2] = p2;
        load_pat[3] = p3; load_pat[4] = p4;
        load_now = 1'b1;
        @(negedge clk);
        load_now = 1'b0;
        repeat (2) @(negedge clk);
        chk(!mem_rd && !mem_wr, "R12", "strobes in reset", 32'({mem_rd, mem_wr}), 0);
        chk(!upd_done && !upd_ready, "R12", "handshake in reset",
            32'({upd_done, upd_ready}), 0);
        rst_n = 1'b1;
    endtask

    // Driver: push the expected result, then issue one request
    task automatic do_upd(input logic [7:0] d, input bit eskip, input logic [7:0] enew,
                          input string req, input bit poke);
        int n = 0;
        wait_ready();
        exp_q.push_back('{skip: eskip, newest: enew, req: req});
        upd_req  = 1'b1;
        upd_data = d;
        @(negedge clk);
        upd_req = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            upd_req  = 1'b1;
            upd_data = 8'h77;
            @(negedge clk);
            upd_req = 1'b0;
        end
        while (exp_q.size() != 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(exp_q.size() == 0, req, "done pulse arrived", 32'(exp_q.size()), 0);
        wait_ready();
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog expired: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int w0;
        // Scenario A: marker at slot 2, newest 0x42 in slot 1
        do_reset(8'h00, 8'h42, 8'hFF, 8'h00, 8'h00);
        wait_ready();
        chk(newest_val == 8'h42, "R2", "restored newest", 32'(newest_val), 32'h42);
        chk(!ring_blank, "R1", "blank flag after marker found", 32'(ring_blank), 0);

        w0 = wr_total;
        do_upd(8'h42, 1'b1, 8'h42, "R4", 1'b0);
        chk(wr_total == w0, "R4", "writes on equal value", 32'(wr_total - w0), 0);

        w0 = wr_total;
        do_upd(8'h10, 1'b0, 8'h10, "R5", 1'b1);   // also pokes a request mid-sequence
        chk(mem[BASE+2] == 8'h10, "R1", "data at first empty slot", 32'(mem[BASE+2]), 32'h10);
        chk(mem[BASE+3] == 8'hFF, "R5", "marker after data", 32'(mem[BASE+3]), 32'hFF);
        chk(wr_total - w0 == 2, "R8", "writes with ignored poke", 32'(wr_total - w0), 2);

        do_upd(8'h11, 1'b0, 8'h11, "R5", 1'b0);
        do_upd(8'h12, 1'b0, 8'h12, "R6", 1'b0);
        chk(mem[BASE+4] == 8'h12, "R6", "data in last slot", 32'(mem[BASE+4]), 32'h12);
        chk(mem[BASE] == 8'hFF, "R6", "marker wrapped to slot 0", 32'(mem[BASE]), 32'hFF);

        busy_len = 9;
        do_upd(8'h13, 1'b0, 8'h13, "R7", 1'b0);
        chk(mem[BASE] == 8'h13, "R6", "write slot wrapped", 32'(mem[BASE]), 32'h13);
        chk(mem[BASE+1] == 8'hFF, "R7", "marker under long busy", 32'(mem[BASE+1]), 32'hFF);
        busy_len = 3;

        w0 = wr_total;
        do_upd(8'hFF, 1'b1, 8'h13, "R9", 1'b0);
        chk(wr_total == w0, "R9", "writes for empty code", 32'(wr_total - w0), 0);
        chk(mem[BASE-1] == 8'hA5 && mem[BASE+LEN] == 8'h5A, "R11", "outside cells",
            32'({mem[BASE-1], mem[BASE+LEN]}), 32'hA55A);

        // Scenario B: fully erased ring, marker write skipped
        do_reset(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
        wait_ready();
        chk(newest_val == 8'hFF && !ring_blank, "R2", "erased ring restore",
            32'({ring_blank, newest_val}), 32'h0FF);
        w0 = wr_total;
        do_upd(8'h05, 1'b0, 8'h05, "R5", 1'b0);
        chk(mem[BASE] == 8'h05, "R5", "data into slot 0", 32'(mem[BASE]), 32'h05);
        chk(wr_total - w0 == 1, "R5", "marker write skipped", 32'(wr_total - w0), 1);

        // Scenario C: marker at slot 0, newest wraps to last slot
        do_reset(8'hFF, 8'h01, 8'h01, 8'h01, 8'h9A);
        wait_ready();
        chk(newest_val == 8'h9A, "R2", "newest from last slot", 32'(newest_val), 32'h9A);
        w0 = wr_total;
        do_upd(8'h9A, 1'b1, 8'h9A, "R4", 1'b0);
        chk(wr_total == w0, "R4", "wrapped compare skip", 32'(wr_total - w0), 0);

        // Scenario D: no marker anywhere; request during scan is ignored
        do_reset(8'h33, 8'h33, 8'h33, 8'h33, 8'h33);
        w0 = wr_total;
        upd_req  = 1'b1;
        upd_data = 8'h44;
        @(negedge clk);
        upd_req = 1'b0;
        wait_ready();
        chk(wr_total == w0, "R8", "request during scan", 32'(wr_total - w0), 0);
        chk(ring_blank, "R3", "blank flag", 32'(ring_blank), 1);
        chk(newest_val == 8'hFF, "R3", "blank newest", 32'(newest_val), 32'hFF);
        do_upd(8'h07, 1'b0, 8'h07, "R3", 1'b0);
        chk(mem[BASE] == 8'h07 && mem[BASE+1] == 8'hFF, "R3", "blank ring starts at slot 0",
            32'({mem[BASE], mem[BASE+1]}), 32'h07FF);
        chk(ring_blank, "R3", "blank flag held", 32'(ring_blank), 1);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule